// File: doc/BRIEF.md
# Byte Register File with Address Pointer Pairs

This block holds thirty-two 8-bit working registers for a small processor core. Two independent read ports return single bytes. One write port stores a single byte. A further pair port reads and writes 16-bit values kept in two adjacent registers, with the low byte in the even register and the high byte in the odd one.

The three highest register pairs also serve as 16-bit data-memory pointers. Each cycle the block drives an effective byte address for the selected pointer. It can use the pointer as it stands, use it and then step it up by one, or step it down by one and use the result. Any change to the pointer is written back into both bytes of its pair on the same clock edge. The data memory, the instruction decoder and the ALU lie outside the block. Every interface is plain and single-cycle. No port has a handshake, because every access completes in the cycle it is presented.

Top module: `ptr_regfile`

## Requirements
- R1: When `rst` is high at a rising clock edge, every register becomes zero on that edge, and no write presented in the same cycle takes effect.
- R2: `rd_a_data` and `rd_b_data` show the register named by `rd_a_idx` and `rd_b_idx` combinationally. Within a cycle they show the contents from before that cycle's edge.
- R3: With `wr_en` high, register `wr_idx` takes `wr_data` at the rising edge, unless a higher-priority write targets the same register.
- R4: `pr_rd_data` equals {register 2k+1, register 2k}, where k is `pr_rd_idx`.
- R5: With `pr_wr_en` high, register 2k takes `pr_wr_data[7:0]` and register 2k+1 takes `pr_wr_data[15:0]`'s upper byte, where k is `pr_wr_idx`. This pair write beats a byte write to either of those registers.
- R6: `ptr_sel` is encoded as 2'b00 for pointer X (pair 13, registers 27:26), 2'b01 for Y (pair 14, registers 29:28) and 2'b10 for Z (pair 15, registers 31:30). The value 2'b11 selects no pointer: `ptr_addr` is 0 and no register changes.
- R7: `ptr_mode` 2'b00 (plain) and 2'b11 both drive the current pointer value on `ptr_addr` and leave the pointer unchanged.
- R8: `ptr_mode` 2'b01 (post-increment) drives the current pointer on `ptr_addr`. When `ptr_en` is high, the pair becomes pointer+1 modulo 2^16 at the edge.
- R9: `ptr_mode` 2'b10 (pre-decrement) drives pointer-1 modulo 2^16 on `ptr_addr`. When `ptr_en` is high, the pair takes that same value at the edge.
- R10: A pointer update overrides both a byte write and a pair write that touch either register of the updated pair. A write to any other register still takes effect in the same cycle.
- R11: With `ptr_en` low, `ptr_addr` still follows `ptr_sel` and `ptr_mode`, but no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| pr_rd_idx | input | 4 | Pair read index |
| pr_rd_data | output | 16 | Pair read data, high byte from odd register |
| pr_wr_en | input | 1 | Pair write enable |
| pr_wr_idx | input | 4 | Pair write index |
| pr_wr_data | input | 16 | Pair write data |
| ptr_en | input | 1 | Pointer access enable (allows update) |
| ptr_sel | input | 2 | Pointer select: X, Y, Z or none |
| ptr_mode | input | 2 | Pointer mode: plain, post-increment, pre-decrement |
| ptr_addr | output | 16 | Effective data-memory byte address |

## Verification
Two functions can collide on the same edge: a pointer update, and a byte or pair write to a register of the pointer's pair. The bench provokes this in directed cycles. In one, a byte write to register 26 is issued together with an X post-increment. In another, a pair write to pair 15 is issued together with a Z pre-decrement. The randomised phase biases write indices toward registers 26 to 31 so that overlaps happen often. Each case is judged against a reference model that applies the writes in rising priority, so the pointer result is the one that survives. The result is then read back through both byte read ports, the pair read port and the pointer address.

// File: rtl/ptr_rf_pkg.sv
package ptr_rf_pkg;

  typedef enum logic [1:0] {
    PSEL_X    = 2'b00,
    PSEL_Y    = 2'b01,
    PSEL_Z    = 2'b10,
    PSEL_NONE = 2'b11
  } ptr_sel_e;

  typedef enum logic [1:0] {
    PMODE_PLAIN  = 2'b00,
    PMODE_POSTINC = 2'b01,
    PMODE_PREDEC = 2'b10,
    PMODE_RSVD   = 2'b11
  } ptr_mode_e;

  localparam int SEL_W  = 2;
  localparam int MODE_W = 2;

endpackage

// File: rtl/ptr_rf_agu.sv
module ptr_rf_agu
  import ptr_rf_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int NPTR  = 3,
  localparam int PW    = 2 * REG_W,
  localparam int PTR_IW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [NPTR-1:0][PW-1:0] ptr_vals,
  input  logic                    ptr_en,
  input  logic [SEL_W-1:0]        ptr_sel,
  input  logic [MODE_W-1:0]       ptr_mode,
  output logic [PW-1:0]           addr,
  output logic                    upd_en,
  output logic [PTR_IW-1:0]       upd_ptr,
  output logic [PW-1:0]           upd_val
);

  logic          sel_ok;
  logic [PW-1:0] cur;
  logic [PW-1:0] nxt;
  logic          steps;

  always_comb begin
    sel_ok  = 1'b0;
    cur     = '0;
    upd_ptr = '0;
    for (int p = 0; p < NPTR; p++) begin
      if (int'(ptr_sel) == p) begin
        sel_ok  = 1'b1;
        cur     = ptr_vals[p];
        upd_ptr = PTR_IW'(p);
      end
    end
  end

  always_comb begin
    steps = 1'b0;
    nxt   = cur;
    addr  = cur;
    unique case (ptr_mode_e'(ptr_mode))
      PMODE_POSTINC: begin
        steps = 1'b1;
        nxt   = cur + PW'(1);
        addr  = cur;
      end
      PMODE_PREDEC: begin
        steps = 1'b1;
        nxt   = cur - PW'(1);
        addr  = nxt;
      end
      default: begin
        steps = 1'b0;
        nxt   = cur;
        addr  = cur;
      end
    endcase
    if (!sel_ok) addr = '0;
  end

  assign upd_en  = ptr_en && sel_ok && steps;
  assign upd_val = nxt;

endmodule

// File: rtl/ptr_rf_storage.sv
module ptr_rf_storage #(
  parameter int REG_W = 8,
  parameter int NREG  = 32,
  parameter int NPTR  = 3,
  localparam int PW     = 2 * REG_W,
  localparam int NPAIR  = NREG / 2,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PIDX_W = $clog2(NPAIR),
  localparam int PTR_IW = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int PTR_BASE = NPAIR - NPTR
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [REG_W-1:0]            wr_data,
  input  logic                        pwr_en,
  input  logic [PIDX_W-1:0]           pwr_idx,
  input  logic [PW-1:0]               pwr_data,
  input  logic                        upd_en,
  input  logic [PTR_IW-1:0]           upd_ptr,
  input  logic [PW-1:0]               upd_val,
  output logic [NREG-1:0][REG_W-1:0]  regs_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int PAIR = g / 2;
    localparam bit HIGH = (g % 2) == 1;

    logic             hit_ptr;
    logic             hit_pair;
    logic             hit_byte;
    logic [REG_W-1:0] ptr_byte;
    logic [REG_W-1:0] pair_byte;
    logic [REG_W-1:0] d;

    if (HIGH) begin : g_hi
      assign ptr_byte  = upd_val[PW-1:REG_W];
      assign pair_byte = pwr_data[PW-1:REG_W];
    end else begin : g_lo
      assign ptr_byte  = upd_val[REG_W-1:0];
      assign pair_byte = pwr_data[REG_W-1:0];
    end

    assign hit_ptr  = upd_en && ((int'(upd_ptr) + PTR_BASE) == PAIR);
    assign hit_pair = pwr_en && (int'(pwr_idx) == PAIR);
    assign hit_byte = wr_en && (int'(wr_idx) == g);

    always_comb begin
      if (hit_ptr)       d = ptr_byte;
      else if (hit_pair) d = pair_byte;
      else if (hit_byte) d = wr_data;
      else               d = regs_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else     regs_q[g] <= d;
    end
  end

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_rf_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int NREG  = 32,
  parameter int NPTR  = 3,
  localparam int PW     = 2 * REG_W,
  localparam int NPAIR  = NREG / 2,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PIDX_W = $clog2(NPAIR),
  localparam int PTR_IW = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int PTR_BASE = NPAIR - NPTR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [REG_W-1:0]  rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [REG_W-1:0]  rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [PIDX_W-1:0] pr_rd_idx,
  output logic [PW-1:0]     pr_rd_data,
  input  logic              pr_wr_en,
  input  logic [PIDX_W-1:0] pr_wr_idx,
  input  logic [PW-1:0]     pr_wr_data,
  input  logic              ptr_en,
  input  logic [SEL_W-1:0]  ptr_sel,
  input  logic [MODE_W-1:0] ptr_mode,
  output logic [PW-1:0]     ptr_addr
);

  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [NPAIR-1:0][PW-1:0]   pairs;
  logic [NPTR-1:0][PW-1:0]    ptr_vals;
  logic                       upd_en;
  logic [PTR_IW-1:0]          upd_ptr;
  logic [PW-1:0]              upd_val;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pairs[k] = {regs_q[2*k+1], regs_q[2*k]};
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptr_vals[p] = pairs[PTR_BASE + p];
  end

  assign rd_a_data  = regs_q[rd_a_idx];
  assign rd_b_data  = regs_q[rd_b_idx];
  assign pr_rd_data = pairs[pr_rd_idx];

  ptr_rf_agu #(.REG_W(REG_W), .NPTR(NPTR)) u_agu (
    .ptr_vals (ptr_vals),
    .ptr_en   (ptr_en),
    .ptr_sel  (ptr_sel),
    .ptr_mode (ptr_mode),
    .addr     (ptr_addr),
    .upd_en   (upd_en),
    .upd_ptr  (upd_ptr),
    .upd_val  (upd_val)
  );

  ptr_rf_storage #(.REG_W(REG_W), .NREG(NREG), .NPTR(NPTR)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .pwr_en   (pr_wr_en),
    .pwr_idx  (pr_wr_idx),
    .pwr_data (pr_wr_data),
    .upd_en   (upd_en),
    .upd_ptr  (upd_ptr),
    .upd_val  (upd_val),
    .regs_q   (regs_q)
  );

endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk #(
  parameter int REG_W = 8,
  parameter int NREG  = 32,
  parameter int NPTR  = 3,
  localparam int PW     = 2 * REG_W,
  localparam int NPAIR  = NREG / 2,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PIDX_W = $clog2(NPAIR),
  localparam int PTR_BASE = NPAIR - NPTR
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [REG_W-1:0]           wr_data,
  input logic                       pr_wr_en,
  input logic [PIDX_W-1:0]          pr_wr_idx,
  input logic                       ptr_en,
  input logic [1:0]                 ptr_sel,
  input logic [1:0]                 ptr_mode,
  input logic [PW-1:0]              ptr_addr,
  input logic [NREG-1:0][REG_W-1:0] regs
);

  logic [NPTR-1:0][PW-1:0] pv;
  for (genvar p = 0; p < NPTR; p++) begin : g_pv
    assign pv[p] = {regs[2*(PTR_BASE+p)+1], regs[2*(PTR_BASE+p)]};
  end

  logic sel_ok, stepping, wr_in_ptr, pwr_in_ptr;
  assign sel_ok     = int'(ptr_sel) < NPTR;
  assign stepping   = ptr_en && sel_ok && (ptr_mode == 2'b01 || ptr_mode == 2'b10);
  assign wr_in_ptr  = wr_en && (int'(wr_idx) / 2 == PTR_BASE + int'(ptr_sel));
  assign pwr_in_ptr = pr_wr_en && (int'(pr_wr_idx) == PTR_BASE + int'(ptr_sel));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (regs == '0));

  assert_nosel_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (ptr_sel == 2'b11) |-> (ptr_addr == '0));

  assert_plain_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_ok && (ptr_mode == 2'b00 || ptr_mode == 2'b11)) |-> (ptr_addr == pv[ptr_sel]));

  assert_postinc_R8: assert property (@(posedge clk) disable iff (rst)
    (stepping && ptr_mode == 2'b01) |=> (pv[$past(ptr_sel)] == $past(ptr_addr) + PW'(1)));

  assert_predec_R9: assert property (@(posedge clk) disable iff (rst)
    (stepping && ptr_mode == 2'b10) |=> (pv[$past(ptr_sel)] == $past(ptr_addr)));

  assert_ptr_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (stepping && (wr_in_ptr || pwr_in_ptr)) |=>
      (pv[$past(ptr_sel)] == (($past(ptr_mode) == 2'b01) ? $past(ptr_addr) + PW'(1) : $past(ptr_addr))));

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(pr_wr_en && int'(pr_wr_idx) == int'(wr_idx) / 2) && !(stepping && wr_in_ptr))
      |=> (regs[$past(wr_idx)] == $past(wr_data)));

  assert_noupd_R11: assert property (@(posedge clk) disable iff (rst)
    (!ptr_en && sel_ok && !wr_in_ptr && !pwr_in_ptr) |=> (pv[$past(ptr_sel)] == $past(pv[ptr_sel])));

endmodule

bind ptr_regfile ptr_regfile_chk #(.REG_W(REG_W), .NREG(NREG), .NPTR(NPTR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .pr_wr_en  (pr_wr_en),
  .pr_wr_idx (pr_wr_idx),
  .ptr_en    (ptr_en),
  .ptr_sel   (ptr_sel),
  .ptr_mode  (ptr_mode),
  .ptr_addr  (ptr_addr),
  .regs      (regs_q)
);

// File: tb/ptr_regfile_bench.sv
`timescale 1ns/1ps
module ptr_regfile_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        wr_en, pr_wr_en, ptr_en;
  logic [3:0]  pr_rd_idx, pr_wr_idx;
  logic [15:0] pr_rd_data, pr_wr_data, ptr_addr;
  logic [1:0]  ptr_sel, ptr_mode;

  int checks = 0;
  int errors = 0;
  int model [32];

  always #2 clk = ~clk;

  ptr_regfile u_ptr_regfile (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pr_rd_idx(pr_rd_idx), .pr_rd_data(pr_rd_data),
    .pr_wr_en(pr_wr_en), .pr_wr_idx(pr_wr_idx), .pr_wr_data(pr_wr_data),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_addr(ptr_addr)
  );

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  function automatic int pair_of(int k);
    return (model[2*k+1] << 8) | model[2*k];
  endfunction

  // One cycle: drive inputs, compare outputs with the model, advance the model.
  task automatic step(string req, bit r, int ra, int rb, int prr,
                      bit we, int wi, int wd, bit pe, int pi, int pd,
                      bit qe, int qs, int qm);
    int cur, exp_addr, nxt;
    bit moves;
    rst = r; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb); pr_rd_idx = 4'(prr);
    wr_en = we; wr_idx = 5'(wi); wr_data = 8'(wd);
    pr_wr_en = pe; pr_wr_idx = 4'(pi); pr_wr_data = 16'(pd);
    ptr_en = qe; ptr_sel = 2'(qs); ptr_mode = 2'(qm);
    #1;
    cur = (qs < 3) ? pair_of(13 + qs) : 0;
    moves = 0; nxt = cur; exp_addr = cur;
    if (qs < 3 && qm == 1) begin moves = 1; nxt = (cur + 1) & 16'hFFFF; end
    if (qs < 3 && qm == 2) begin moves = 1; nxt = (cur - 1) & 16'hFFFF; exp_addr = nxt; end
    check(req, "rd_a", int'(rd_a_data), model[ra]);
    check(req, "rd_b", int'(rd_b_data), model[rb]);
    check(req, "pair_rd", int'(pr_rd_data), pair_of(prr));
    check(req, "ptr_addr", int'(ptr_addr), exp_addr);
    if (r) begin
      foreach (model[i]) model[i] = 0;
    end else begin
      if (we) model[wi] = wd & 8'hFF;
      if (pe) begin model[2*pi] = pd & 8'hFF; model[2*pi+1] = (pd >> 8) & 8'hFF; end
      if (qe && moves) begin model[2*(13+qs)] = nxt & 8'hFF; model[2*(13+qs)+1] = nxt >> 8; end
    end
    @(negedge clk);
  endtask

  task automatic idle(string req, int ra, int rb, int prr, int qs, int qm);
    step(req, 0, ra, rb, prr, 0, 0, 0, 0, 0, 0, 0, qs, qm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    @(negedge clk);
    step("R1", 1, 0, 1, 0, 1, 3, 8'h5A, 1, 2, 16'hBEEF, 1, 0, 1);
    step("R1", 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) idle("R1", 2*i, 2*i+1, i, 0, 0);

    // byte writes, read back through both ports
    step("R3", 0, 0, 0, 0, 1, 5, 8'hA5, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 4, 0, 0, 1, 4, 8'h3C, 0, 0, 0, 0, 0, 0);
    idle("R2", 5, 4, 2, 0, 0);
    idle("R4", 4, 5, 2, 3, 0);
    // pair write beats byte write to same register
    step("R5", 0, 6, 7, 3, 1, 7, 8'h11, 1, 3, 16'hC0DE, 0, 0, 0);
    idle("R5", 6, 7, 3, 0, 0);

    // load pointers through pair port
    step("R6", 0, 26, 27, 13, 0, 0, 0, 1, 13, 16'h1234, 0, 0, 0);
    step("R6", 0, 28, 29, 14, 0, 0, 0, 1, 14, 16'h0000, 0, 0, 0);
    step("R6", 0, 30, 31, 15, 0, 0, 0, 1, 15, 16'hFFFF, 0, 0, 0);
    idle("R7", 26, 27, 13, 0, 0);
    idle("R7", 28, 29, 14, 1, 3);
    step("R7", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    step("R8", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    step("R9", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 1, 0, 2);
    step("R8", 0, 30, 31, 15, 0, 0, 0, 0, 0, 0, 1, 2, 1);
    idle("R8", 30, 31, 15, 2, 0);
    step("R9", 0, 28, 29, 14, 0, 0, 0, 0, 0, 0, 1, 1, 2);
    idle("R9", 28, 29, 14, 1, 0);
    step("R6", 0, 26, 31, 13, 0, 0, 0, 0, 0, 0, 1, 3, 1);
    step("R6", 0, 26, 31, 15, 0, 0, 0, 0, 0, 0, 1, 3, 2);
    step("R11", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R11", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    step("R7", 0, 26, 27, 13, 0, 0, 0, 0, 0, 0, 1, 0, 3);

    // collisions
    step("R10", 0, 26, 27, 13, 1, 26, 8'h77, 0, 0, 0, 1, 0, 1);
    idle("R10", 26, 27, 13, 0, 0);
    step("R10", 0, 30, 31, 15, 0, 0, 0, 1, 15, 16'hAAAA, 1, 2, 2);
    idle("R10", 30, 31, 15, 2, 0);
    step("R10", 0, 28, 9, 4, 1, 9, 8'h42, 1, 14, 16'h5555, 1, 2, 1);
    idle("R10", 28, 9, 14, 2, 0);

    for (int n = 0; n < 4000; n++) begin
      int wi, pi;
      wi = ($urandom_range(0, 1) == 1) ? int'($urandom_range(26, 31)) : int'($urandom_range(0, 31));
      pi = ($urandom_range(0, 1) == 1) ? int'($urandom_range(13, 15)) : int'($urandom_range(0, 15));
      step("R2 R10 random", ($urandom_range(0, 199) == 0),
           int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 1)), wi, int'($urandom_range(0, 255)),
           bit'($urandom_range(0, 3) == 0), pi, int'($urandom_range(0, 65535)),
           bit'($urandom_range(0, 2) != 0), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end

    step("R1", 1, 0, 0, 0, 1, 26, 8'hFF, 1, 13, 16'hFFFF, 1, 0, 1);
    for (int i = 0; i < 16; i++) idle("R1", 2*i, 2*i+1, i, 2, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule